// File: doc/BRIEF.md
# Prescaled 16-bit Compare-Clear Timer

This block is a 16-bit up-counting timer for the system clock domain. Every divided rate is a one-cycle enable pulse, so the block has no derived clocks. A clock-gear setting first divides the system clock by 1, 2, 4, 8 or 16. A fixed divide-by-8 stage follows it, and its output advances a 5-bit prescaler. The prescaler has three taps, at 1/2, 1/8 and 1/32 of its input rate. The counter advances on one of these taps or on rising edges of an external clock pin. The external pin passes through a two-flop synchronizer first.

In free-running mode the counter wraps from its maximum value to zero. Each wrap raises a one-cycle overflow pulse. In clear mode the counter returns to zero on the count event after it has equalled the compare register, and this return raises no overflow. Software uses a plain write port and a combinational read port. Through them it sets the mode, the two run bits and the compare value, and it reads back the live count.

Top module: `gear_timer`

## Requirements
- R1: With the prescaler running, the count rises by one every 8·2^g·t system cycles. Here g is the gear code in mode bits [5:3] (codes 0 to 4) and t is the selected tap ratio (2, 8 or 32). Gear codes 5 to 7 behave as code 4.
- R2: Mode bits [1:0] select the count source: 00 is the external pin, 01 is prescaler/2, 10 is prescaler/8, 11 is prescaler/32.
- R3: When the prescaler run bit (run register bit 1) is 0, the prescaler is held at zero and no tap pulse occurs. A tap-clocked counter then keeps its value.
- R4: When the external source is selected, each rising edge of ext_clk_i advances the count by exactly one. Each level must be held for at least two cycles.
- R5: When the counter run bit (run register bit 0) is 0, the count reads zero from the next cycle on and no overflow is raised.
- R6: When mode bit 2 (clear enable) is 1, a count event taken while the count equals the compare value loads zero. This raises no overflow, even when the compare value is the maximum.
- R7: When clear is disabled, a count event at the maximum value wraps the count to zero. ovf_o is then high for exactly one cycle, the cycle in which the count first reads zero.
- R8: A write to the compare register takes effect for the next count event. A compare value below the current count is reached only after a wrap.
- R9: Read address 0 returns the mode fields, 1 returns the run bits, 2 returns the compare value and 3 returns the live count. All values are zero-extended. Write addresses 0 to 2 load the same registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | DATA_W | Read data (combinational) |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| ovf_o | output | 1 | Overflow pulse, one cycle |

## Verification
The assertions check the following on every cycle:
- the count is forced to zero when counter run is off;
- the prescaler is held at zero when prescaler run is off;
- each count event is a single increment, and the count is stable when no event occurs;
- a compare clear gives zero without an overflow;
- every overflow pulse follows the maximum count and lands on a zero count.

Only the bench scenarios can show the following:
- the absolute counting periods for every gear and tap pair;
- the external edge count;
- the clamping of out-of-range gear codes;
- compare values at the maximum and below the current count;
- the register read-back map.

// File: rtl/gear_timer_pkg.sv
package gear_timer_pkg;
  typedef enum logic [1:0] {
    SRC_EXT = 2'b00,
    SRC_T2  = 2'b01,
    SRC_T8  = 2'b10,
    SRC_T32 = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic [2:0] gear;
    logic       clr_en;
    src_sel_e   src;
  } mode_t;

  localparam int unsigned MODE_W   = $bits(mode_t);
  localparam logic [1:0]  ADR_MODE = 2'd0;
  localparam logic [1:0]  ADR_RUN  = 2'd1;
  localparam logic [1:0]  ADR_CMP  = 2'd2;
  localparam logic [1:0]  ADR_CNT  = 2'd3;
endpackage

// File: rtl/gear_timer_base.sv
// Gear divider followed by fixed divide-by-8, as an enable pulse.
module gear_timer_base #(
  parameter int unsigned GEAR_MAX = 4,
  parameter int unsigned FIX_LOG  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [2:0] gear_i,
  output logic       base_en_o
);
  localparam int unsigned DIV_W = GEAR_MAX + FIX_LOG;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic [2:0]       gear_eff;

  always_comb begin
    gear_eff = (gear_i > 3'(GEAR_MAX)) ? 3'(GEAR_MAX) : gear_i;
    mask     = (DIV_W'(1) << (gear_eff + 3'(FIX_LOG))) - DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!run_i) div_q <= '0;
    else             div_q <= div_q + DIV_W'(1);
  end

  assign base_en_o = run_i && ((div_q & mask) == mask);
endmodule

// File: rtl/gear_timer_psc.sv
// Prescaler with taps at 1/2, 1/8, 1/32 (tap i divides by 2^(2i+1)).
module gear_timer_psc #(
  parameter int unsigned NUM_TAPS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                base_en_i,
  output logic [NUM_TAPS-1:0] tap_en_o,
  output logic [2*NUM_TAPS-2:0] psc_o
);
  localparam int unsigned PSC_W = 2 * NUM_TAPS - 1;

  logic [PSC_W-1:0] psc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        psc_q <= '0;
    else if (!run_i)    psc_q <= '0;
    else if (base_en_i) psc_q <= psc_q + PSC_W'(1);
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tap_en_o[i] = run_i && base_en_i && (&psc_q[2*i:0]);
  end

  assign psc_o = psc_q;
endmodule

// File: rtl/gear_timer_ext.sv
// Two-flop synchronizer plus rising edge detect.
module gear_timer_ext (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/gear_timer_cnt.sv
module gear_timer_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cnt_en_i,
  input  logic             clr_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             hit;

  assign hit = clr_en_i && (cnt_q == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (cnt_en_i) begin
        if (hit) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
          ovf_q <= &cnt_q;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/gear_timer.sv
module gear_timer
  import gear_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned GEAR_MAX = 4,
  parameter int unsigned NUM_TAPS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ext_clk_i,
  output logic              ovf_o
);
  localparam int unsigned PSC_W = 2 * NUM_TAPS - 1;

  mode_t            mode_q;
  logic             run_q, prun_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt;
  logic             base_en, ext_rise, cnt_en;
  logic [NUM_TAPS-1:0] tap_en;
  logic [PSC_W-1:0] psc_val;
  logic             unused_wr;

  assign unused_wr = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= 1'b0;
      prun_q <= 1'b0;
      cmp_q  <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADR_MODE: mode_q <= mode_t'(wr_data_i[MODE_W-1:0]);
        ADR_RUN: begin
          run_q  <= wr_data_i[0];
          prun_q <= wr_data_i[1];
        end
        ADR_CMP: cmp_q <= wr_data_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADR_MODE: rd_data_o[MODE_W-1:0] = mode_q;
      ADR_RUN:  rd_data_o[1:0]        = {prun_q, run_q};
      ADR_CMP:  rd_data_o[CNT_W-1:0]  = cmp_q;
      default:  rd_data_o[CNT_W-1:0]  = cnt;
    endcase
  end

  gear_timer_base #(.GEAR_MAX(GEAR_MAX), .FIX_LOG(3)) u_base (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (prun_q),
    .gear_i   (mode_q.gear),
    .base_en_o(base_en)
  );

  gear_timer_psc #(.NUM_TAPS(NUM_TAPS)) u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (prun_q),
    .base_en_i(base_en),
    .tap_en_o (tap_en),
    .psc_o    (psc_val)
  );

  gear_timer_ext u_ext (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ext_i (ext_clk_i),
    .rise_o(ext_rise)
  );

  always_comb begin
    unique case (mode_q.src)
      SRC_EXT: cnt_en = ext_rise;
      SRC_T2:  cnt_en = tap_en[0];
      SRC_T8:  cnt_en = tap_en[1];
      default: cnt_en = tap_en[2];
    endcase
  end

  gear_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .cnt_en_i(cnt_en),
    .clr_en_i(mode_q.clr_en),
    .cmp_i   (cmp_q),
    .cnt_o   (cnt),
    .ovf_o   (ovf_o)
  );
endmodule

// File: rtl/gear_timer_chk.sv
module gear_timer_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_q,
  input logic             prun_q,
  input logic             clr_en,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cmp_q,
  input logic [CNT_W-1:0] cnt,
  input logic [PSC_W-1:0] psc_val,
  input logic             ovf_o
);
  a_r5_run_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> (cnt == '0) && !ovf_o);

  a_r3_psc_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prun_q |=> (psc_val == '0));

  a_r6_clear_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cnt_en && clr_en && (cnt == cmp_q) |=> (cnt == '0) && !ovf_o);

  a_r1_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cnt_en && !(clr_en && (cnt == cmp_q)) |=> cnt == $past(cnt) + CNT_W'(1));

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !cnt_en |=> $stable(cnt));

  a_r7_ovf_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (cnt == '0));

  a_r7_ovf_from_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> ($past(cnt) == {CNT_W{1'b1}}));

  a_r7_ovf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);
endmodule

bind gear_timer gear_timer_chk #(.CNT_W(CNT_W), .PSC_W(2 * NUM_TAPS - 1)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_q  (run_q),
  .prun_q (prun_q),
  .clr_en (mode_q.clr_en),
  .cnt_en (cnt_en),
  .cmp_q  (cmp_q),
  .cnt    (cnt),
  .psc_val(psc_val),
  .ovf_o  (ovf_o)
);

// File: tb/tb_gear_timer.sv
module tb_gear_timer;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0]        rd_addr = 2'd3;
  logic [DATA_W-1:0] rd_data;
  logic              ext = 1'b0;
  logic              ovf;

  int errors = 0;
  int checks = 0;
  int ovf_cnt = 0;
  int ovf_run = 0;
  int ovf_max_run = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gear_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .ext_clk_i(ext),
    .ovf_o    (ovf)
  );

  always @(posedge clk) begin
    if (rst_n && ovf) begin
      ovf_cnt++;
      ovf_run++;
      if (ovf_run > ovf_max_run) ovf_max_run = ovf_run;
    end else begin
      ovf_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext = 1'b1;
      repeat (2) @(negedge clk);
      ext = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // cycles between two successive count changes
  task automatic period(output int p);
    int prev;
    int n;
    n = 0;
    prev = int'(rd_data);
    while (int'(rd_data) == prev && n < 10000) begin @(negedge clk); n++; end
    prev = int'(rd_data);
    n = 0;
    while (int'(rd_data) == prev && n < 10000) begin @(negedge clk); n++; end
    p = n;
  endtask

  initial begin
    repeat (20000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int p;
    int base_ovf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R9, R7)
    check(rd_data == 0, "R9 reset count", int'(rd_data), 0);
    rd_addr = 2'd0; #0;
    check(rd_data == 0, "R9 reset mode", int'(rd_data), 0);
    rd_addr = 2'd3;
    check(ovf == 1'b0, "R7 reset ovf", int'(ovf), 0);

    // R1/R2: sweep gear 0..4 plus clamped 6, all three taps
    for (int g = 0; g <= 6; g++) begin
      if (g == 5) continue;
      for (int s = 1; s <= 3; s++) begin
        int ge;
        int t;
        ge = (g > 4) ? 4 : g;
        t  = (s == 1) ? 2 : (s == 2) ? 8 : 32;
        wr(2'd1, 0);
        wr(2'd0, (g << 3) | s);
        wr(2'd1, 3);
        period(p);
        check(p == 8 * (1 << ge) * t, $sformatf("R1 R2 gear=%0d sel=%0d", g, s), p, 8 * (1 << ge) * t);
      end
    end

    // R3: prescaler stopped, tap source, counter running
    wr(2'd1, 0);
    wr(2'd0, 1);
    wr(2'd1, 1);
    repeat (400) @(negedge clk);
    check(rd_data == 0, "R3 prescaler off holds count", int'(rd_data), 0);
    wr(2'd1, 3);
    repeat (100) @(negedge clk);
    wr(2'd1, 1);
    p = int'(rd_data);
    repeat (300) @(negedge clk);
    check(int'(rd_data) == p && p != 0, "R3 freeze after stop", int'(rd_data), p);

    // R5: counter run off clears
    wr(2'd1, 2);
    @(negedge clk);
    check(rd_data == 0, "R5 run off zero", int'(rd_data), 0);

    // R4: external edges
    wr(2'd0, 0);
    wr(2'd1, 1);
    pulses(37);
    check(rd_data == 37, "R4 ext edge count", int'(rd_data), 37);
    repeat (50) @(negedge clk);
    check(rd_data == 37, "R4 no edge no count", int'(rd_data), 37);

    // R6: compare clear
    base_ovf = ovf_cnt;
    wr(2'd1, 0);
    wr(2'd2, 5);
    wr(2'd0, 4);
    wr(2'd1, 1);
    pulses(5);
    check(rd_data == 5, "R6 reach compare", int'(rd_data), 5);
    pulses(1);
    check(rd_data == 0, "R6 clear on match", int'(rd_data), 0);
    pulses(1);
    check(rd_data == 1, "R6 count after clear", int'(rd_data), 1);

    // R6: compare at max, no overflow
    wr(2'd1, 0);
    wr(2'd2, 255);
    wr(2'd1, 1);
    pulses(256);
    check(rd_data == 0, "R6 max compare clear", int'(rd_data), 0);
    check(ovf_cnt == base_ovf, "R6 no ovf on clear", ovf_cnt, base_ovf);

    // R7: free-run wrap
    wr(2'd1, 0);
    wr(2'd0, 0);
    wr(2'd1, 1);
    pulses(255);
    check(rd_data == 255, "R7 at max", int'(rd_data), 255);
    pulses(1);
    check(rd_data == 0, "R7 wrap to zero", int'(rd_data), 0);
    check(ovf_cnt == base_ovf + 1, "R7 one ovf", ovf_cnt, base_ovf + 1);
    check(ovf_max_run == 1, "R7 ovf one cycle", ovf_max_run, 1);

    // R8: compare written below count
    wr(2'd1, 0);
    wr(2'd1, 1);
    pulses(10);
    wr(2'd2, 3);
    wr(2'd0, 4);
    pulses(246);
    check(rd_data == 0, "R8 wrap past low compare", int'(rd_data), 0);
    check(ovf_cnt == base_ovf + 2, "R8 wrap ovf", ovf_cnt, base_ovf + 2);
    pulses(3);
    check(rd_data == 3, "R8 reach compare", int'(rd_data), 3);
    pulses(1);
    check(rd_data == 0, "R8 clear after wrap", int'(rd_data), 0);

    // R9: read-back map
    wr(2'd0, (3 << 3) | 4 | 2);
    wr(2'd1, 2);
    wr(2'd2, 200);
    rd_addr = 2'd0; #1;
    check(rd_data == 16'h1E, "R9 mode read", int'(rd_data), 'h1E);
    rd_addr = 2'd1; #1;
    check(rd_data == 2, "R9 run read", int'(rd_data), 2);
    rd_addr = 2'd2; #1;
    check(rd_data == 200, "R9 cmp read", int'(rd_data), 200);
    rd_addr = 2'd3; #1;
    check(rd_data == 0, "R9 count read", int'(rd_data), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule